// File: doc/BRIEF.md
# Burst Address Generator

This block issues a run of address-channel bursts on an AXI read or write port, together covering one contiguous memory region. Software or a control sequencer sets it up over a narrow configuration port that takes one word per cycle. The first word must match a selection code so that the block knows it is being addressed. The next word is the start byte address, and the word after that is the number of data beats to move. Once the count word is taken, the block walks the region burst by burst. Every burst uses incrementing addressing, and the transaction ID is fixed at zero. The data channels are expected to complete in order and without error, so no response is examined.

The beat size and the address stride both follow from the data-width parameter. All bursts carry the full length parameter except the last one, which is cut down to the beats that remain. A one-cycle completion pulse marks the moment the final burst is accepted. A busy flag tells the configuring side that any new setup words will be dropped.

Top module: `burst_addr_gen`

## Requirements
- R1: After a synchronous active-high reset, `ax_valid`, `busy` and `done` are all low.
- R2: Setup is a fixed three-word sequence, each word on a cycle with `cfg_valid` high. The first word must equal `SEL_CODE`, the second is the start address and the third is the beat count. A first word that differs from `SEL_CODE` is dropped and the block stays idle.
- R3: The first burst of a job carries the start address given in the setup sequence.
- R4: On every burst, `ax_id` is zero and `ax_burst` is 2'b01 (incrementing).
- R5: `ax_size` equals log2(DATA_W/8). With a 64-bit bus this is 3.
- R6: After each accepted burst, the next burst address is the previous one plus (DATA_W/8)*BURST_LEN bytes.
- R7: `ax_len` is the beat count minus one. Every burst has BURST_LEN beats except a final burst, which has the remaining beats when fewer than BURST_LEN are left. The beats of a job add up to the requested count.
- R8: While `ax_valid` is high and `ax_ready` is low, `ax_valid`, `ax_addr` and `ax_len` hold their values into the next cycle.
- R9: `done` is high for exactly one cycle, the cycle after the last burst of a job is accepted. At no other time is it high.
- R10: `busy` is high while `ax_valid` is high. Setup words that arrive while `busy` is high are dropped and cause no bursts.
- R11: A beat count of zero starts no job. It produces no burst, no `done` pulse and no `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Setup word present |
| cfg_data | input | ADDR_W | Setup word (selection code, address or count) |
| ax_addr | output | ADDR_W | Burst start byte address |
| ax_len | output | 8 | Beats in burst minus one |
| ax_size | output | 3 | log2 of bytes per beat |
| ax_burst | output | 2 | Burst type, always incrementing |
| ax_id | output | ID_W | Transaction ID, always zero |
| ax_valid | output | 1 | Address burst valid |
| ax_ready | input | 1 | Address burst accepted by the port |
| busy | output | 1 | Job in progress; setup is dropped |
| done | output | 1 | One-cycle pulse after the last accepted burst |

## Verification
The bench builds the block with a 64-bit data bus and a burst length of 4, with 32-bit addresses and a 16-bit count. With these values the size code is 3 and the stride is 32 bytes. A short count then reaches the shortened final burst, and an exact multiple of four shows that no extra burst is issued. A job of three bursts held under a stalled ready gives a long busy window. During that window the bench injects a stray setup sequence and checks the hold-stable rule.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

    typedef enum logic [1:0] {
        CFG_IDLE  = 2'd0,
        CFG_ADDR  = 2'd1,
        CFG_COUNT = 2'd2
    } cfg_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/addr_gen_cfg.sv
module addr_gen_cfg
    import addr_gen_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                CNT_W    = 16,
    parameter logic [ADDR_W-1:0] SEL_CODE = ADDR_W'(32'h0000_00A5)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              eng_busy,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W-1:0]  start_count
);

    typedef struct packed {
        cfg_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
        logic              start;
    } cfg_regs_t;

    cfg_regs_t q, d;
    logic [CNT_W-1:0] count_word;

    assign count_word = cfg_data[CNT_W-1:0];

    always_comb begin
        d       = q;
        d.start = 1'b0;
        case (q.state)
            CFG_IDLE: begin
                if (cfg_valid && !eng_busy && !q.start && cfg_data == SEL_CODE)
                    d.state = CFG_ADDR;
            end
            CFG_ADDR: begin
                if (cfg_valid) begin
                    d.addr  = cfg_data;
                    d.state = CFG_COUNT;
                end
            end
            CFG_COUNT: begin
                if (cfg_valid) begin
                    d.count = count_word;
                    d.start = (count_word != '0);
                    d.state = CFG_IDLE;
                end
            end
            default: d.state = CFG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state <= CFG_IDLE;
            q.addr  <= '0;
            q.count <= '0;
            q.start <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign start       = q.start;
    assign start_addr  = q.addr;
    assign start_count = q.count;

    // R2
    start_after_count_chk: assert property (@(posedge clk) disable iff (rst)
        q.start |-> ($past(q.state) == CFG_COUNT));

    // R10
    no_setup_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (q.state != CFG_IDLE) |-> !eng_busy);

    // R11
    no_zero_start_chk: assert property (@(posedge clk) disable iff (rst)
        q.start |-> (q.count != '0));

endmodule

// File: rtl/addr_gen_engine.sv
module addr_gen_engine #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 64,
    parameter int BURST_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              ax_ready,
    output logic [ADDR_W-1:0] ax_addr,
    output logic [7:0]        ax_len,
    output logic [2:0]        ax_size,
    output logic              ax_valid,
    output logic              done
);

    localparam int BYTES     = DATA_W / 8;
    localparam int SIZE_CODE = $clog2(BYTES);
    localparam int STRIDE    = BYTES * BURST_LEN;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BURST_LEN);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  remain;
        logic              valid;
        logic              done;
    } eng_regs_t;

    eng_regs_t q, d;
    logic [CNT_W-1:0] beats;
    logic             accept;

    assign beats  = (q.remain >= FULL) ? FULL : q.remain;
    assign accept = q.valid && ax_ready;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.addr   = start_addr;
            d.remain = start_count;
            d.valid  = 1'b1;
        end else if (accept) begin
            d.addr   = q.addr + ADDR_W'(STRIDE);
            d.remain = q.remain - beats;
            if (q.remain == beats) begin
                d.valid = 1'b0;
                d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.addr   <= '0;
            q.remain <= '0;
            q.valid  <= 1'b0;
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ax_addr  = q.addr;
    assign ax_len   = 8'(beats - 1'b1);
    assign ax_size  = 3'(SIZE_CODE);
    assign ax_valid = q.valid;
    assign done     = q.done;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (q.valid && !ax_ready) |=> (q.valid && $stable(q.addr) && $stable(ax_len)));

    // R6
    stride_step_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && q.valid && (q.remain != beats)) |=>
            (q.addr == $past(q.addr) + ADDR_W'(STRIDE)));

    // R7
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        q.valid |-> (ax_len <= 8'(BURST_LEN - 1) && q.remain != '0));

    // R9
    done_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        q.done |-> ($past(accept) && !q.valid));

    // R10
    no_start_while_active_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !q.valid);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import addr_gen_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                CNT_W     = 16,
    parameter int                DATA_W    = 64,
    parameter int                BURST_LEN = 16,
    parameter int                ID_W      = 4,
    parameter logic [ADDR_W-1:0] SEL_CODE  = ADDR_W'(32'h0000_00A5)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [ADDR_W-1:0] cfg_data,
    output logic [ADDR_W-1:0] ax_addr,
    output logic [7:0]        ax_len,
    output logic [2:0]        ax_size,
    output logic [1:0]        ax_burst,
    output logic [ID_W-1:0]   ax_id,
    output logic              ax_valid,
    input  logic              ax_ready,
    output logic              busy,
    output logic              done
);

    logic              start;
    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W-1:0]  start_count;
    logic              eng_busy;

    addr_gen_cfg #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .SEL_CODE(SEL_CODE)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_valid  (cfg_valid),
        .cfg_data   (cfg_data),
        .eng_busy   (eng_busy),
        .start      (start),
        .start_addr (start_addr),
        .start_count(start_count)
    );

    addr_gen_engine #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .DATA_W   (DATA_W),
        .BURST_LEN(BURST_LEN)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .start_count(start_count),
        .ax_ready   (ax_ready),
        .ax_addr    (ax_addr),
        .ax_len     (ax_len),
        .ax_size    (ax_size),
        .ax_valid   (eng_busy),
        .done       (done)
    );

    assign ax_valid = eng_busy;
    assign busy     = eng_busy | start;
    assign ax_burst = BURST_INCR;
    assign ax_id    = '0;

    // R10
    busy_covers_valid_chk: assert property (@(posedge clk) disable iff (rst)
        ax_valid |-> busy);

    // R9
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 64;
    localparam int BL     = 4;
    localparam int ID_W   = 4;
    localparam logic [31:0] SEL = 32'h0000_00A5;
    localparam int STRIDE = (DATA_W / 8) * BL;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  len;
        logic        last;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_valid = 1'b0;
    logic [ADDR_W-1:0] cfg_data = '0;
    logic [ADDR_W-1:0] ax_addr;
    logic [7:0]        ax_len;
    logic [2:0]        ax_size;
    logic [1:0]        ax_burst;
    logic [ID_W-1:0]   ax_id;
    logic              ax_valid;
    logic              ax_ready = 1'b0;
    logic              busy;
    logic              done;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   ready_mode = 0;
    int   done_seen = 0;
    int   jobs = 0;
    int   cycles = 0;
    bit   exp_done = 1'b0;
    bit   prev_stall = 1'b0;
    logic [31:0] prev_addr;
    logic [7:0]  prev_len;

    always #5 clk = ~clk;

    burst_addr_gen #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
        .BURST_LEN(BL), .ID_W(ID_W), .SEL_CODE(SEL)
    ) dut (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
        .ax_addr(ax_addr), .ax_len(ax_len), .ax_size(ax_size),
        .ax_burst(ax_burst), .ax_id(ax_id), .ax_valid(ax_valid),
        .ax_ready(ax_ready), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: ax_ready <= 1'b1;
            1: ax_ready <= 1'($urandom % 2);
            default: ax_ready <= 1'b0;
        endcase
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            finish_run();
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done || exp_done)
                check(done == exp_done, "R9 done pulse", 64'(done), 64'(exp_done));
            if (done) done_seen++;
            exp_done = 1'b0;
            if (prev_stall) begin
                check(ax_valid && ax_addr == prev_addr && ax_len == prev_len,
                      "R8 hold under stall", 64'(ax_addr), 64'(prev_addr));
            end
            if (ax_valid)
                check(busy == 1'b1, "R10 busy with valid", 64'(busy), 64'd1);
            if (ax_valid && ax_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R10 unexpected burst", 64'(ax_addr), 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(ax_addr == e.addr, "R3/R6 address", 64'(ax_addr), 64'(e.addr));
                    check(ax_len == e.len, "R7 length", 64'(ax_len), 64'(e.len));
                    check(ax_size == 3'd3, "R5 size", 64'(ax_size), 64'd3);
                    check(ax_burst == 2'b01 && ax_id == '0, "R4 type and id",
                          64'({ax_burst, ax_id}), 64'({2'b01, 4'b0}));
                    if (e.last) exp_done = 1'b1;
                end
            end
            prev_stall = ax_valid && !ax_ready;
            prev_addr  = ax_addr;
            prev_len   = ax_len;
        end
    end

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_data  = w;
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_data  = '0;
    endtask

    task automatic send_setup(input logic [31:0] sel, input logic [31:0] a,
                              input logic [31:0] n);
        send_word(sel);
        send_word(a);
        send_word(n);
    endtask

    task automatic run_job(input logic [31:0] a, input int n);
        logic [31:0] addr = a;
        int rem = n;
        while (rem > 0) begin
            int b = (rem >= BL) ? BL : rem;
            exp_t e;
            e.addr = addr;
            e.len  = 8'(b - 1);
            e.last = (rem == b);
            exp_q.push_back(e);
            addr = addr + STRIDE;
            rem  = rem - b;
        end
        if (n > 0) jobs++;
        send_setup(SEL, a, 32'(n));
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0 || busy);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!ax_valid && !busy && !done, "R1 reset state",
              64'({ax_valid, busy, done}), 64'd0);

        // R7 shortened final burst, R3, R6
        ready_mode = 0;
        run_job(32'h0000_1000, 10);
        wait_idle();
        // R7 exact multiple
        ready_mode = 1;
        run_job(32'h0001_0000, 8);
        wait_idle();
        // R7 single beat
        run_job(32'h0000_0040, 1);
        wait_idle();
        check(exp_q.size() == 0, "R7 beats sum", 64'(exp_q.size()), 64'd0);

        // R11 zero count
        send_setup(SEL, 32'h0000_5000, 32'd0);
        repeat (5) @(negedge clk);
        check(!busy && !ax_valid, "R11 zero count idle",
              64'({busy, ax_valid}), 64'd0);

        // R2 wrong select word
        send_setup(32'h0000_0011, 32'h0000_3000, 32'd4);
        repeat (5) @(negedge clk);
        check(!busy && !ax_valid, "R2 wrong select ignored",
              64'({busy, ax_valid}), 64'd0);

        // R10 setup while busy, R8 stall
        ready_mode = 2;
        run_job(32'h0000_2000, 12);
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R10 busy during job", 64'(busy), 64'd1);
        send_setup(SEL, 32'h0000_9000, 32'd4);
        repeat (4) @(negedge clk);
        ready_mode = 1;
        wait_idle();
        repeat (10) @(negedge clk);
        check(!ax_valid && exp_q.size() == 0, "R10 setup during busy dropped",
              64'(ax_valid), 64'd0);

        // R2 recovery: valid sequence after a stray word
        ready_mode = 0;
        send_word(32'h0000_0077);
        run_job(32'h0000_8000, 5);
        wait_idle();

        // R9 one done per job
        check(done_seen == jobs, "R9 done count", 64'(done_seen), 64'(jobs));
        finish_run();
    end

endmodule